// File: doc/BRIEF.md
# Fuse ROM read controller

This block sits between a register bus and a one-time-programmable fuse macro of 8 Kbit. The macro is split into a lower and an upper 4 Kbit half, and a chip-select line picks between them. Software first loads a timing register with two read timing counts, measured in bus-clock cycles. It then writes a control word that holds a byte address, a byte count and a start bit. The controller walks the macro one 32-bit word at a time. For each word it drives the address and chip select, waits out the setup time, raises the strobe for the access window and samples the returned word at the end of that window. It repeats this until the requested bytes are covered.

Captured words are held back until the whole command has finished. Then they are committed together into eight 32-bit data buffer registers, so software never sees a half-updated buffer. Completion sets a done flag. If interrupts are enabled, the interrupt line follows that flag. Software clears the flag by writing 1 to it. The program-enable and write-enable bits and the write timing fields are only stored and read back: this controller never drives a write or programming pulse.

Top module: `fuse_rd_ctrl`

## Requirements
- R1: After reset every register reads zero. The byte offsets are 0x00 for control, 0x04 for timing, 0x08 for status and 0x0C+4*n for data word n (n = 0..7). Any other offset reads zero.
- R2: Control bits 15 (program enable) and 1 (write enable) are stored and read back. Setting them never raises fuse_strobe or fuse_cs and never changes status or data.
- R3: The timing register keeps bit 31 (interrupt enable), 23:20 (read setup), 19:16 (read width), 15:12 (write setup) and 11:0 (write width). Bits 30:24 read zero.
- R4: A write to control while idle stores bit 30 (chip select), 29:21 (byte address) and 20:16 (byte count minus one). If bit 0 is 1, the write starts a read and clears done. Control bit 0 reads 1 while the read runs and reads 0 once it completes.
- R5: Each word access lasts setup+width+5 cycles. In the first setup+1 cycles fuse_strobe is low while the address is held. In the remaining width+4 cycles fuse_strobe is high. The word is sampled on the last strobe cycle.
- R6: A read fetches count[4:2]+1 whole words. Word k is fetched at fuse_addr = {(address[8:2]+k) mod 128, 2'b00}.
- R7: During a read, fuse_cs equals control bit 30. When idle, fuse_cs is 0.
- R8: When a read completes, data words 0..count[4:2] receive the fetched words in order and the other data words keep their values. While a read runs, the data words still hold the results of the previous completed read.
- R9: Status bit 0 is done and bit 1 is always 0. Writing 1 to status bit 0 clears done. If that write lands on the completion edge, done ends up set.
- R10: irq is high exactly when done is set and timing bit 31 is 1.
- R11: Writes to control or timing while a read runs are ignored. This includes a write that lands on the completion edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all timing counts are in its cycles |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| fuse_cs | output | 1 | Selects the upper 4 Kbit half of the macro |
| fuse_addr | output | 9 | Byte address of the word being read, word aligned |
| fuse_strobe | output | 1 | Read strobe to the macro |
| fuse_rdata | input | 32 | Word returned by the macro |
| irq | output | 1 | Read-complete interrupt |

## Verification
Two pairs of events can land on the same edge. The first pair is a software acknowledge of done and the completion of a read. The second pair is a control write and that same completion. The bench uses the shortest timing, a one-word read of five cycles, and counts edges from the start write so that the status write, or a second start write, lands exactly on the completion edge. It then checks that done and irq are set, that control bit 0 reads 0 and that the control fields did not change, so no second read began. A cycle-by-cycle reference model predicts strobe, address, chip select and irq on every clock, so any drift by one cycle in either ordering is reported.

// File: rtl/fuse_rd_pkg.sv
// Shared constants and register field types for the fuse ROM read controller.
// Assumes a 32-bit register bus and a macro read one 32-bit word at a time.
package fuse_rd_pkg;
    localparam int DATA_W    = 32;
    localparam int NUM_WORDS = 8;
    localparam int ADDR_W    = 9;
    localparam int LEN_W     = 5;
    localparam int TIME_W    = 4;
    localparam int WWIDTH_W  = 12;
    localparam int WIDX_W    = $clog2(NUM_WORDS);
    localparam int WADDR_W   = ADDR_W - 2;

    // Register word indices (byte offset / 4)
    localparam int OFF_CTRL  = 0;
    localparam int OFF_TIME  = 1;
    localparam int OFF_STAT  = 2;
    localparam int OFF_DBUF  = 3;
    localparam int REG_AW    = $clog2((OFF_DBUF + NUM_WORDS) * 4);

    // Control field positions
    localparam int CTL_CS    = 30;
    localparam int CTL_ADDR  = 21;
    localparam int CTL_LEN   = 16;
    localparam int CTL_PROG  = 15;
    localparam int CTL_WREN  = 1;
    localparam int CTL_GO    = 0;

    // Timing field positions
    localparam int TIM_IE    = 31;
    localparam int TIM_RSET  = 20;
    localparam int TIM_RWID  = 16;
    localparam int TIM_WSET  = 12;
    localparam int TIM_WWID  = 0;

    typedef struct packed {
        logic              cs;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic              prog_en;
        logic              wr_en;
    } ctrl_t;

    typedef struct packed {
        logic                irq_en;
        logic [TIME_W-1:0]   rd_setup;
        logic [TIME_W-1:0]   rd_width;
        logic [TIME_W-1:0]   wr_setup;
        logic [WWIDTH_W-1:0] wr_width;
    } tcfg_t;
endpackage

// File: rtl/fuse_rd_regs.sv
// Control, timing and done-flag registers.
// Assumes busy and fin come from the sequencer; fin marks the completion edge.
module fuse_rd_regs
    import fuse_rd_pkg::*;
#(
    parameter int IDX_W = REG_AW - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    input  logic              fin,
    output ctrl_t             ctrl_q,
    output tcfg_t             tcfg_q,
    output logic              done_q,
    output logic              start
);
    logic wr_ctrl, wr_tcfg, ack;

    // Decode bus writes; control and timing are locked while busy
    always_comb begin
        wr_ctrl = wr_en && (wr_idx == IDX_W'(OFF_CTRL)) && !busy;
        wr_tcfg = wr_en && (wr_idx == IDX_W'(OFF_TIME)) && !busy;
        ack     = wr_en && (wr_idx == IDX_W'(OFF_STAT)) && wr_data[0];
        start   = wr_ctrl && wr_data[CTL_GO];
    end

    // Control register storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q.cs      <= wr_data[CTL_CS];
            ctrl_q.addr    <= wr_data[CTL_ADDR +: ADDR_W];
            ctrl_q.len     <= wr_data[CTL_LEN +: LEN_W];
            ctrl_q.prog_en <= wr_data[CTL_PROG];
            ctrl_q.wr_en   <= wr_data[CTL_WREN];
        end
    end

    // Timing register storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tcfg_q <= '0;
        end else if (wr_tcfg) begin
            tcfg_q.irq_en   <= wr_data[TIM_IE];
            tcfg_q.rd_setup <= wr_data[TIM_RSET +: TIME_W];
            tcfg_q.rd_width <= wr_data[TIM_RWID +: TIME_W];
            tcfg_q.wr_setup <= wr_data[TIM_WSET +: TIME_W];
            tcfg_q.wr_width <= wr_data[TIM_WWID +: WWIDTH_W];
        end
    end

    // Done flag: completion wins over an acknowledge on the same edge
    always_ff @(posedge clk) begin
        if (!rst_n)              done_q <= 1'b0;
        else if (fin)            done_q <= 1'b1;
        else if (start || ack)   done_q <= 1'b0;
    end

    AST_TIMING_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(tcfg_q)); // R11
    AST_CTRL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(ctrl_q)); // R11
    AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !done_q); // R4
    AST_FIN_SETS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> done_q); // R9
endmodule

// File: rtl/fuse_rd_seq.sv
// Read sequencer: per word, holds address for setup+1 cycles, then strobes
// for width+4 cycles and samples on the last one. Assumes timing and control
// inputs stay constant while busy (the register block locks them).
module fuse_rd_seq
    import fuse_rd_pkg::*;
#(
    parameter int NW    = NUM_WORDS,
    parameter int TW    = TIME_W,
    parameter int WAW   = WADDR_W,
    localparam int IW   = $clog2(NW),
    localparam int CNT_W = TW + 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [TW-1:0]   rd_setup,
    input  logic [TW-1:0]   rd_width,
    input  logic [WAW-1:0]  base_word,
    input  logic [IW-1:0]   last_word,
    input  logic            chip_sel,
    output logic            busy,
    output logic            fuse_cs,
    output logic [WAW+1:0]  fuse_addr,
    output logic            fuse_strobe,
    output logic            cap_valid,
    output logic            cap_last,
    output logic [IW-1:0]   cap_idx
);
    logic [CNT_W-1:0] cnt, last_cnt;
    logic [IW-1:0]    widx;

    // Derive access window end and macro-facing signals
    always_comb begin
        last_cnt    = CNT_W'(rd_setup) + CNT_W'(rd_width) + CNT_W'(4);
        cap_valid   = busy && (cnt == last_cnt);
        cap_last    = cap_valid && (widx == last_word);
        cap_idx     = widx;
        fuse_strobe = busy && (cnt > CNT_W'(rd_setup));
        fuse_cs     = busy && chip_sel;
        fuse_addr   = {base_word + WAW'(widx), 2'b00};
    end

    // Cycle and word counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
            widx <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= '0;
            widx <= '0;
        end else if (busy) begin
            if (cap_valid) begin
                cnt <= '0;
                if (cap_last) busy <= 1'b0;
                else          widx <= widx + IW'(1);
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    AST_ADDR_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fuse_strobe) |-> $stable(fuse_addr)); // R5
    AST_SAMPLE_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |-> fuse_strobe); // R5
    AST_ONE_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |=> !cap_valid); // R5
    AST_LAST_ENDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        cap_last |=> !busy); // R4
endmodule

// File: rtl/fuse_rd_dbuf.sv
// Data buffer with staging: words land in a staging file during a read and
// are committed together on the last sample. Assumes cap_idx rises from 0.
module fuse_rd_dbuf
    import fuse_rd_pkg::*;
#(
    parameter int NW = NUM_WORDS,
    parameter int DW = DATA_W,
    localparam int IW = $clog2(NW)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cap_valid,
    input  logic                   cap_last,
    input  logic [IW-1:0]          cap_idx,
    input  logic [DW-1:0]          cap_data,
    output logic [NW-1:0][DW-1:0]  words
);
    logic [NW-1:0][DW-1:0] stage;

    for (genvar g = 0; g < NW; g++) begin : g_word
        localparam logic [IW-1:0] GI = IW'(g);

        // Staging slot for word g
        always_ff @(posedge clk) begin
            if (!rst_n)                            stage[g] <= '0;
            else if (cap_valid && cap_idx == GI)   stage[g] <= cap_data;
        end

        // Visible word g, updated only at completion
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                words[g] <= '0;
            end else if (cap_last) begin
                if (cap_idx == GI)     words[g] <= cap_data;
                else if (GI < cap_idx) words[g] <= stage[g];
            end
        end
    end

    AST_BUF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_last |=> $stable(words)); // R8
endmodule

// File: rtl/fuse_rd_ctrl.sv
// Top of the fuse ROM read controller: register decode, read mux, irq.
// Assumes the macro returns the addressed word combinationally while strobed.
module fuse_rd_ctrl
    import fuse_rd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              fuse_cs,
    output logic [ADDR_W-1:0] fuse_addr,
    output logic              fuse_strobe,
    input  logic [DATA_W-1:0] fuse_rdata,
    output logic              irq
);
    localparam int IDX_W = REG_AW - 2;
    localparam logic [IDX_W-1:0] I_CTRL = IDX_W'(OFF_CTRL);
    localparam logic [IDX_W-1:0] I_TIME = IDX_W'(OFF_TIME);
    localparam logic [IDX_W-1:0] I_STAT = IDX_W'(OFF_STAT);
    localparam logic [IDX_W-1:0] I_DBUF = IDX_W'(OFF_DBUF);
    localparam logic [IDX_W-1:0] I_DEND = IDX_W'(OFF_DBUF + NUM_WORDS);

    logic [IDX_W-1:0] idx;
    logic             unused_lsb;
    ctrl_t            ctrl_q;
    tcfg_t            tcfg_q;
    logic             done_q, start, busy, fin, cap_valid;
    logic [WIDX_W-1:0] cap_idx;
    logic [NUM_WORDS-1:0][DATA_W-1:0] words;

    assign idx        = reg_addr[REG_AW-1:2];
    assign unused_lsb = ^reg_addr[1:0];

    fuse_rd_regs #(.IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .wr_idx(idx),
        .wr_data(reg_wdata), .busy(busy), .fin(fin),
        .ctrl_q(ctrl_q), .tcfg_q(tcfg_q), .done_q(done_q), .start(start)
    );

    fuse_rd_seq u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .rd_setup(tcfg_q.rd_setup), .rd_width(tcfg_q.rd_width),
        .base_word(ctrl_q.addr[ADDR_W-1:2]), .last_word(ctrl_q.len[LEN_W-1:2]),
        .chip_sel(ctrl_q.cs), .busy(busy), .fuse_cs(fuse_cs),
        .fuse_addr(fuse_addr), .fuse_strobe(fuse_strobe),
        .cap_valid(cap_valid), .cap_last(fin), .cap_idx(cap_idx)
    );

    fuse_rd_dbuf u_dbuf (
        .clk(clk), .rst_n(rst_n), .cap_valid(cap_valid), .cap_last(fin),
        .cap_idx(cap_idx), .cap_data(fuse_rdata), .words(words)
    );

    // Interrupt follows the done flag when enabled
    assign irq = done_q && tcfg_q.irq_en;

    // Register read multiplexer
    always_comb begin
        reg_rdata = '0;
        case (idx)
            I_CTRL: begin
                reg_rdata[CTL_CS]                = ctrl_q.cs;
                reg_rdata[CTL_ADDR +: ADDR_W]    = ctrl_q.addr;
                reg_rdata[CTL_LEN +: LEN_W]      = ctrl_q.len;
                reg_rdata[CTL_PROG]              = ctrl_q.prog_en;
                reg_rdata[CTL_WREN]              = ctrl_q.wr_en;
                reg_rdata[CTL_GO]                = busy;
            end
            I_TIME: begin
                reg_rdata[TIM_IE]                = tcfg_q.irq_en;
                reg_rdata[TIM_RSET +: TIME_W]    = tcfg_q.rd_setup;
                reg_rdata[TIM_RWID +: TIME_W]    = tcfg_q.rd_width;
                reg_rdata[TIM_WSET +: TIME_W]    = tcfg_q.wr_setup;
                reg_rdata[TIM_WWID +: WWIDTH_W]  = tcfg_q.wr_width;
            end
            I_STAT: reg_rdata[0] = done_q;
            default: begin
                if (idx >= I_DBUF && idx < I_DEND)
                    reg_rdata = words[WIDX_W'(idx - I_DBUF)];
            end
        endcase
    end

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> tcfg_q.irq_en); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!fuse_strobe && !fuse_cs)); // R2
endmodule

// File: tb/tb_fuse_rd_ctrl.sv
// Bench with a behavioural fuse macro and a cycle-level reference model.
module tb_fuse_rd_ctrl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_we;
    logic [5:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata, fuse_rdata;
    logic        fuse_cs, fuse_strobe, irq;
    logic [8:0]  fuse_addr;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    fuse_rd_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fuse_cs(fuse_cs),
        .fuse_addr(fuse_addr), .fuse_strobe(fuse_strobe),
        .fuse_rdata(fuse_rdata), .irq(irq)
    );

    // Macro content: distinct word for each {half, word index}
    function automatic logic [31:0] fword(input logic [7:0] i);
        return {i, ~i, i ^ 8'h5A, i + 8'h33};
    endfunction

    assign fuse_rdata = fuse_strobe ? fword({fuse_cs, fuse_addr[8:2]}) : 32'h0;

    function automatic logic [31:0] mkctl(input logic cs, input logic [8:0] a,
                                          input logic [4:0] len, input logic pg,
                                          input logic we, input logic go);
        logic [31:0] r;
        r = '0;
        r[30] = cs; r[29:21] = a; r[20:16] = len; r[15] = pg; r[1] = we; r[0] = go;
        return r;
    endfunction

    // Reference model state
    int          m_busy, m_t, m_T, m_setup, m_n, m_base7, m_cs, m_done;
    logic [31:0] m_ctl, m_tim;
    logic [31:0] m_buf [8];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_t = 0; m_T = 5; m_setup = 0; m_n = 1;
            m_base7 = 0; m_cs = 0; m_done = 0; m_ctl = '0; m_tim = '0;
            for (int k = 0; k < 8; k++) m_buf[k] = '0;
        end else begin
            bit fin, st;
            fin = (m_busy != 0) && (m_t == m_n * m_T - 1);
            st  = 0;
            if (reg_we) begin
                case (reg_addr[5:2])
                    4'd0: if (m_busy == 0) begin
                        m_ctl = reg_wdata & 32'h7FFF_8002;
                        if (reg_wdata[0]) begin
                            st = 1; m_busy = 1; m_t = 0; m_done = 0;
                            m_setup = int'(m_tim[23:20]);
                            m_T = m_setup + int'(m_tim[19:16]) + 5;
                            m_n = int'(reg_wdata[20:18]) + 1;
                            m_base7 = int'(reg_wdata[29:23]);
                            m_cs = int'(reg_wdata[30]);
                        end
                    end
                    4'd1: if (m_busy == 0) m_tim = reg_wdata & 32'h80FF_FFFF;
                    4'd2: if (reg_wdata[0]) m_done = 0;
                    default: ;
                endcase
            end
            if (fin) begin
                m_busy = 0;
                for (int k = 0; k < m_n; k++)
                    m_buf[k] = fword({m_cs[0], 7'(m_base7 + k)});
                m_done = 1;
            end else if (m_busy != 0 && !st) begin
                m_t++;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Per-cycle comparison of macro-facing outputs and irq
    always @(negedge clk) begin
        if (rst_n === 1'b1 && !finished) begin
            if (m_busy != 0) begin
                int k, c;
                k = m_t / m_T;
                c = m_t % m_T;
                chk("R5 strobe", {31'b0, fuse_strobe}, {31'b0, (c >= m_setup + 1)});
                chk("R6 address", {23'b0, fuse_addr}, {23'b0, 7'(m_base7 + k), 2'b00});
                chk("R7 chip select", {31'b0, fuse_cs}, 32'(m_cs));
            end else begin
                chk("R2 idle strobe", {31'b0, fuse_strobe}, 32'h0);
                chk("R7 idle chip select", {31'b0, fuse_cs}, 32'h0);
            end
            chk("R10 irq", {31'b0, irq}, {31'b0, (m_done != 0) && m_tim[31]});
        end
    end

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_done();
        logic [31:0] v;
        int guard;
        guard = 0;
        v = '0;
        while (v[0] !== 1'b1 && guard < 500) begin
            rd(6'h08, v);
            guard++;
        end
        chk("R4 read completes", {31'b0, v[0]}, 32'h1);
    endtask

    task automatic report();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog act=hung exp=finished");
        report();
    end

    initial begin
        logic [31:0] v;
        rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        rd(6'h00, v); chk("R1 control reset", v, 32'h0);
        rd(6'h04, v); chk("R1 timing reset", v, 32'h0);
        rd(6'h08, v); chk("R1 status reset", v, 32'h0);
        rd(6'h0C, v); chk("R1 data0 reset", v, 32'h0);
        rd(6'h28, v); chk("R1 data7 reset", v, 32'h0);
        rd(6'h2C, v); chk("R1 unmapped offset", v, 32'h0);

        // R3 timing fields
        wr(6'h04, 32'hFFFF_FFFF);
        rd(6'h04, v); chk("R3 timing mask", v, 32'h80FF_FFFF);
        wr(6'h04, 32'h0023_5ABC);
        rd(6'h04, v); chk("R3 timing readback", v, 32'h0023_5ABC);

        // R2 program/write enable stored, no effect
        wr(6'h00, 32'hFFFF_FFFE);
        rd(6'h00, v); chk("R2 control readback", v, 32'h7FFF_8002);
        repeat (10) @(negedge clk);
        rd(6'h08, v); chk("R2 status untouched", v, 32'h0);
        rd(6'h0C, v); chk("R2 data untouched", v, 32'h0);

        // R4/R5/R6/R8 full 32-byte read, lower half
        wr(6'h00, mkctl(1'b0, 9'h010, 5'd31, 1'b0, 1'b0, 1'b1));
        rd(6'h00, v); chk("R4 go bit while busy", {31'b0, v[0]}, 32'h1);
        wait_done();
        rd(6'h00, v); chk("R4 go bit cleared", {31'b0, v[0]}, 32'h0);
        for (int k = 0; k < 8; k++) begin
            rd(6'(12 + 4 * k), v);
            chk("R8 data after full read", v, fword(8'(4 + k)));
        end
        rd(6'h08, v); chk("R9 status after read", v, 32'h1);

        // R6 wrap, R7 upper half, R8 partial update, R11 locked writes
        wr(6'h04, 32'h8010_0000);
        wr(6'h00, mkctl(1'b1, 9'h1F8, 5'd9, 1'b0, 1'b0, 1'b1));
        rd(6'h08, v); chk("R4 start clears done", v, 32'h0);
        rd(6'h0C, v); chk("R8 data held during read", v, fword(8'd4));
        wr(6'h04, 32'h0000_0000);
        rd(6'h04, v); chk("R11 timing write ignored", v, 32'h8010_0000);
        wr(6'h00, mkctl(1'b0, 9'h000, 5'd0, 1'b0, 1'b0, 1'b1));
        rd(6'h00, v); chk("R11 control write ignored",
                          v, mkctl(1'b1, 9'h1F8, 5'd9, 1'b0, 1'b0, 1'b1));
        wait_done();
        rd(6'h0C, v); chk("R6 word 0 upper", v, fword({1'b1, 7'h7E}));
        rd(6'h10, v); chk("R6 word 1 upper", v, fword({1'b1, 7'h7F}));
        rd(6'h14, v); chk("R6 wrapped word 2", v, fword({1'b1, 7'h00}));
        for (int k = 3; k < 8; k++) begin
            rd(6'(12 + 4 * k), v);
            chk("R8 untouched word kept", v, fword(8'(4 + k)));
        end
        chk("R10 irq raised", {31'b0, irq}, 32'h1);

        // R9 acknowledge
        wr(6'h08, 32'h0000_0002);
        rd(6'h08, v); chk("R9 write of bit1 leaves done", v, 32'h1);
        wr(6'h08, 32'h0000_0001);
        rd(6'h08, v); chk("R9 acknowledge clears done", v, 32'h0);
        chk("R10 irq cleared", {31'b0, irq}, 32'h0);

        // R9 acknowledge on the completion edge (1 word, 5 cycles)
        wr(6'h04, 32'h8000_0000);
        wr(6'h00, mkctl(1'b0, 9'h000, 5'd3, 1'b0, 1'b0, 1'b1));
        repeat (3) @(negedge clk);
        wr(6'h08, 32'h0000_0001);
        rd(6'h08, v); chk("R9 completion beats acknowledge", v, 32'h1);
        chk("R10 irq after collision", {31'b0, irq}, 32'h1);
        rd(6'h0C, v); chk("R8 single word", v, fword(8'h00));

        // R11 control write on the completion edge
        wr(6'h00, mkctl(1'b0, 9'h020, 5'd3, 1'b0, 1'b0, 1'b1));
        repeat (3) @(negedge clk);
        wr(6'h00, mkctl(1'b1, 9'h040, 5'd31, 1'b0, 1'b0, 1'b1));
        rd(6'h00, v); chk("R11 write at completion ignored",
                          v, mkctl(1'b0, 9'h020, 5'd3, 1'b0, 1'b0, 1'b0));
        rd(6'h08, v); chk("R11 no second read", v, 32'h1);
        rd(6'h0C, v); chk("R8 word from 0x020", v, fword(8'h08));

        // R5 longest timing
        wr(6'h04, 32'h00FF_0000);
        wr(6'h00, mkctl(1'b0, 9'h0FC, 5'd0, 1'b0, 1'b0, 1'b1));
        wait_done();
        rd(6'h0C, v); chk("R5 slowest access data", v, fword(8'h3F));
        rd(6'h10, v); chk("R8 word 1 kept", v, m_buf[1]);

        report();
    end
endmodule